// File: doc/BRIEF.md
# I2C Target with 16-bit Register Pointer

This block lets an external I2C master read and write a bank of 16-bit registers inside the chip. It oversamples the serial clock and data lines with the system clock, recognises start, repeated-start and stop conditions, and answers only to its own 7-bit device address. It acknowledges bytes by pulling the data line low through an output enable, so the pad itself stays open-drain.

Every access goes through a 16-bit register pointer. A write-direction transfer loads the pointer from its first two bytes, high byte first. Every later pair of bytes forms one data word, high byte first, and is written to the register the pointer names. A read-direction transfer returns the register at the pointer, high byte first, for as long as the master acknowledges. A random-location read is a pointer load followed by a repeated start in read direction. A read issued with no pointer load carries on from the pointer left by the previous transfer. The pointer advances by one register after each complete word.

On the register side the block drives an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is expected one clock after the read strobe, which is block-RAM timing.

Top module: `i2c_reg16_target`

## Requirements
- R1: After reset, sda_oe is 0, reg_we and reg_re are 0 and reg_addr is 0.
- R2: The first byte after a start holds the device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The byte is acknowledged only when bits 7..1 equal DEV_ADDR. On a mismatch SDA stays released until the next start or stop, and no strobe fires.
- R3: In a write-direction transfer, the first two bytes load reg_addr high byte first, and both bytes are acknowledged.
- R4: Each following pair of bytes is acknowledged byte by byte and produces exactly one single-cycle reg_we with reg_wdata = {first byte, second byte}. The strobe fires after the second byte, at the address held by the pointer.
- R5: After each complete 16-bit word, written or read, reg_addr advances by one. A word that is read is complete once its low byte has been shifted out.
- R6: In a read-direction transfer, the block shifts out the register at the pointer high byte first, MSB first. A single-cycle reg_re precedes the first byte of every word.
- R7: A read-direction transfer with no pointer load begins at the pointer value left by the previous transfer.
- R8: A no-acknowledge from the master after a read byte ends the read. SDA then stays released and no further reg_re fires until a start or stop.
- R9: A start or stop at any point clears the byte progress. A word cut short by a repeated start is not written, and the next byte is treated as an address byte.
- R10: SDA is sampled on a rising SCL edge, and sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_rdata | input | 16 | Register read data, valid one cycle after reg_re |
| reg_re | output | 1 | Register read strobe, one cycle |

## Verification
The bench runs several patterns. A two-word sequential write shows that byte pairing and pointer advance are correct. A four-byte random read ending in a no-acknowledge separates the high byte from the low byte and the ack-driven fetch from the stop on no-acknowledge. A current-location read shows that the pointer is carried over between transfers, and a foreign address shows that the block stays silent. A repeated start after half a data word must discard that half-word and then accept a new pointer load. Throughout the run, the bench watches that the data-line enable never moves while SCL is high.

// File: rtl/i2c_reg16_pkg.sv
package i2c_reg16_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 16;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_TXNEXT,
    ST_WAIT
  } tgt_state_e;

  typedef enum logic [1:0] {
    SLOT_PTR_HI,
    SLOT_PTR_LO,
    SLOT_DAT_HI,
    SLOT_DAT_LO
  } wr_slot_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    bus_start = scl_s & scl_q & sda_q & ~sda_s;
    bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_reg16_ctrl.sv
module i2c_reg16_ctrl
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              reg_re
);
  localparam int HALF_W = WORD_W / 2;

  tgt_state_e          state;
  wr_slot_e            slot;
  logic [2:0]          bit_cnt;
  logic [BYTE_W-2:0]   rx_sr;
  logic [BYTE_W-2:0]   tx_sr;
  logic [BYTE_W-1:0]   ptr_hi;
  logic [BYTE_W-1:0]   dat_hi;
  logic [WORD_W-1:0]   rd_word;
  logic                is_read;
  logic                tx_lo;
  logic                inc_pend;
  logic                fetch_d;
  logic [BYTE_W-1:0]   rx_byte;
  logic [BYTE_W-1:0]   next_tx;

  assign rx_byte = {rx_sr, sda_lvl};
  assign next_tx = tx_lo ? rd_word[HALF_W-1:0] : rd_word[WORD_W-1:HALF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= SLOT_PTR_HI;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      ptr_hi    <= '0;
      dat_hi    <= '0;
      rd_word   <= '0;
      is_read   <= 1'b0;
      tx_lo     <= 1'b0;
      inc_pend  <= 1'b0;
      fetch_d   <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      reg_re   <= 1'b0;
      inc_pend <= 1'b0;
      fetch_d  <= reg_re;
      if (fetch_d) rd_word <= reg_rdata;
      if (inc_pend) reg_addr <= reg_addr + 1'b1;

      if (bus_start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (bus_stop) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sr   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
              if (rx_byte[7:1] == DEV_ADDR) begin
                is_read <= rx_byte[0];
                slot    <= SLOT_PTR_HI;
                state   <= ST_ACKW;
                if (rx_byte[0]) begin
                  reg_re <= 1'b1;
                  tx_lo  <= 1'b0;
                end
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            rx_sr   <= rx_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
              state <= ST_ACKW;
              case (slot)
                SLOT_PTR_HI: begin
                  ptr_hi <= rx_byte;
                  slot   <= SLOT_PTR_LO;
                end
                SLOT_PTR_LO: begin
                  reg_addr <= {ptr_hi, rx_byte};
                  slot     <= SLOT_DAT_HI;
                end
                SLOT_DAT_HI: begin
                  dat_hi <= rx_byte;
                  slot   <= SLOT_DAT_LO;
                end
                default: begin
                  reg_wdata <= {dat_hi, rx_byte};
                  reg_we    <= 1'b1;
                  inc_pend  <= 1'b1;
                  slot      <= SLOT_DAT_HI;
                end
              endcase
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              tx_sr  <= rd_word[WORD_W-2:HALF_W];
              sda_oe <= ~rd_word[WORD_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_TXACK;
              tx_lo   <= ~tx_lo;
              if (tx_lo) inc_pend <= 1'b1;
            end else begin
              tx_sr   <= {tx_sr[BYTE_W-3:0], 1'b0};
              sda_oe  <= ~tx_sr[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_TXACK: if (scl_rise) begin
            if (sda_lvl) begin
              state <= ST_WAIT;
            end else begin
              state <= ST_TXNEXT;
              if (!tx_lo) reg_re <= 1'b1;
            end
          end
          ST_TXNEXT: if (scl_fall) begin
            tx_sr   <= next_tx[BYTE_W-2:0];
            sda_oe  <= ~next_tx[BYTE_W-1];
            bit_cnt <= '0;
            state   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: a word produces a single-cycle write strobe
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R5: the pointer steps by one right after a word is written
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

  // R8 / R2: while ignoring the bus the data line is never pulled
  p_wait_released_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe);

  // R9: a start always leads to a fresh address byte
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (state == ST_ADDR && bit_cnt == 3'd0 && !sda_oe));

  // R10: the data-line enable moves only with SCL low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(bus_start) && !$past(bus_stop)) |-> !$past(scl_lvl));
endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target
  import i2c_reg16_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h3C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  input  logic [15:0] reg_rdata,
  output logic        reg_re
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s)
  );

  i2c_bus_events u_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_reg16_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_s), .sda_lvl(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re)
  );
endmodule

// File: tb/i2c_reg16_target_bench.sv
module i2c_reg16_target_bench;
  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h3C;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [15:0] reg_addr, reg_wdata, rdata_q;
  logic        reg_we, reg_re;
  wire         sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0, we_cnt = 0, re_cnt = 0, oe_viol = 0;
  bit done = 0;
  logic prev_oe = 1'b0;
  logic [15:0] mem [0:255];

  i2c_reg16_target u_i2c_reg16_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(rdata_q), .reg_re(reg_re)
  );

  function automatic logic [15:0] seed(input int i);
    return 16'(i * 257) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (reg_re) rdata_q <= mem[reg_addr[7:0]];
    if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
    if (!rst) begin
      if (reg_we) we_cnt <= we_cnt + 1;
      if (reg_re) re_cnt <= re_cnt + 1;
    end
  end

  // R10 monitor: the enable may only move while the bench holds SCL low
  always @(negedge clk) begin
    if (!rst && m_scl && (sda_oe !== prev_oe)) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; hold();
    m_scl = 1'b1; hold(); hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    b = sda_line; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic byte_out(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acked = !b;
  endtask

  task automatic byte_in(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(!ack);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
    chk(reg_re == 1'b0, "R1 reg_re after reset", reg_re, 0);
    chk(reg_addr == 16'h0, "R1 reg_addr after reset", reg_addr, 0);
  endtask

  task automatic t_seq_write();
    logic a0, a1, a2, a3, a4, a5, a6;
    int w0;
    w0 = we_cnt;
    bus_start();
    byte_out({MY_ADDR, 1'b0}, a0);
    chk(a0, "R2 own address acked", a0, 1);
    byte_out(8'h00, a1);
    byte_out(8'h12, a2);
    chk(a1 && a2, "R3 pointer bytes acked", {a1, a2}, 3);
    byte_out(8'hBE, a3);
    byte_out(8'hEF, a4);
    byte_out(8'h12, a5);
    byte_out(8'h34, a6);
    chk(a3 && a4 && a5 && a6, "R4 data bytes acked", {a3, a4, a5, a6}, 15);
    bus_stop();
    chk(we_cnt - w0 == 2, "R4 one strobe per word", we_cnt - w0, 2);
    chk(mem[8'h12] == 16'hBEEF, "R4 first word high-first", mem[8'h12], 16'hBEEF);
    chk(mem[8'h13] == 16'h1234, "R4 second word", mem[8'h13], 16'h1234);
    chk(reg_addr == 16'h0014, "R5 pointer after two words", reg_addr, 16'h0014);
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] b0, b1, b2, b3;
    int r0;
    bus_start();
    byte_out({MY_ADDR, 1'b0}, a);
    byte_out(8'h00, a);
    byte_out(8'h12, a);
    r0 = re_cnt;
    bus_rstart();
    byte_out({MY_ADDR, 1'b1}, a);
    chk(a, "R2 read address acked", a, 1);
    byte_in(1'b1, b0);
    byte_in(1'b1, b1);
    byte_in(1'b1, b2);
    byte_in(1'b0, b3);
    chk({b0, b1} == 16'hBEEF, "R6 random read word 0", {b0, b1}, 16'hBEEF);
    chk({b2, b3} == 16'h1234, "R6 random read word 1", {b2, b3}, 16'h1234);
    chk(re_cnt - r0 == 2, "R6 one read strobe per word", re_cnt - r0, 2);
    chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    bus_stop();
    chk(reg_addr == 16'h0014, "R5 pointer after read words", reg_addr, 16'h0014);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] b0, b1;
    bus_start();
    byte_out({MY_ADDR, 1'b1}, a);
    byte_in(1'b1, b0);
    byte_in(1'b0, b1);
    bus_stop();
    chk({b0, b1} == seed(8'h14), "R7 current location read", {b0, b1}, seed(8'h14));
    chk(reg_addr == 16'h0015, "R5 pointer after current read", reg_addr, 16'h0015);
  endtask

  task automatic t_foreign();
    logic a0, a1, a2;
    int w0;
    int r0;
    logic [15:0] p0;
    w0 = we_cnt; r0 = re_cnt; p0 = reg_addr;
    bus_start();
    byte_out({7'h33, 1'b0}, a0);
    byte_out(8'h00, a1);
    byte_out(8'h50, a2);
    bus_stop();
    chk(!a0, "R2 foreign address not acked", a0, 0);
    chk(!a1 && !a2, "R2 later bytes not acked", {a1, a2}, 0);
    chk(we_cnt == w0 && re_cnt == r0, "R2 no strobes", we_cnt - w0 + re_cnt - r0, 0);
    chk(reg_addr == p0, "R2 pointer untouched", reg_addr, p0);
  endtask

  task automatic t_nack_stop();
    logic a;
    logic b;
    logic [7:0] v;
    int r0;
    int ones;
    bus_start();
    byte_out({MY_ADDR, 1'b0}, a);
    byte_out(8'h00, a);
    byte_out(8'h20, a);
    bus_rstart();
    r0 = re_cnt;
    byte_out({MY_ADDR, 1'b1}, a);
    byte_in(1'b0, v);
    chk(v == seed(8'h20) >> 8, "R6 high byte sent first", v, seed(8'h20) >> 8);
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      bit_in(b);
      if (b) ones++;
    end
    chk(ones == 9, "R8 line stays released after nack", ones, 9);
    chk(re_cnt - r0 == 1, "R8 no fetch after nack", re_cnt - r0, 1);
    bus_stop();
    chk(reg_addr == 16'h0020, "R5 no advance on half word", reg_addr, 16'h0020);
  endtask

  task automatic t_rstart_mid_word();
    logic a, a2;
    int w0;
    w0 = we_cnt;
    bus_start();
    byte_out({MY_ADDR, 1'b0}, a);
    byte_out(8'h00, a);
    byte_out(8'h30, a);
    byte_out(8'h77, a);
    bus_rstart();
    byte_out({MY_ADDR, 1'b0}, a2);
    chk(a2, "R9 address byte expected after rstart", a2, 1);
    byte_out(8'h00, a);
    byte_out(8'h40, a);
    byte_out(8'h11, a);
    byte_out(8'h22, a);
    bus_stop();
    chk(mem[8'h30] == seed(8'h30), "R9 cut word not written", mem[8'h30], seed(8'h30));
    chk(mem[8'h40] == 16'h1122, "R9 new pointer used", mem[8'h40], 16'h1122);
    chk(we_cnt - w0 == 1, "R9 single strobe", we_cnt - w0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = seed(i);
    rdata_q = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_seq_write();
    t_random_read();
    t_current_read();
    t_foreign();
    t_nack_stop();
    t_rstart_mid_word();
    chk(oe_viol == 0, "R10 enable moved with SCL high", oe_viol, 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule